// File: doc/BRIEF.md
# Output Termination Sense and Hot-Plug Interrupt Controller

This block sits beside the analog and digital output stages of a video output device. Software uses it to find out which of three analog outputs have a load attached. Setting a sense control bit freezes the analog outputs at a steady level. Clearing that bit again samples one comparator result per output into read-only status bits. Comparator results come in as plain logic levels, where 1 means that output is unterminated.

The block also watches a hot-plug-detect input through a synchronizer and always reports its current level. When the digital output is selected and the hot-plug level changes in either direction, an interrupt is latched. The latch pulls a shared, open-drain interrupt pin low, but only when both an interrupt-enable bit and a pin-driver-enable bit are set. Software clears the latch by raising a clear-request bit and then lowering it.

Access is through a byte-wide register port with a write strobe and a combinational read path.

Top module: `hpd_sense_ctrl`

## Requirements
- R1: After reset, every register bit reads 0, `dac_hold` is 0 and `irq_pull_low` is 0.
- R2: The sense register at address 0x20 holds the sense control in bit 0, which is read/write. `dac_hold` equals the stored sense bit from the clock edge after the write.
- R3: A write to 0x20 that makes bit 0 go from 1 to 0 loads `dac_cmp[2:0]` into bits 3:1, with `dac_cmp[0]` going into bit 1. A status bit of 1 means unconnected.
- R4: Status bits 3:1 keep their value through every other write, including a 0-to-0 or 1-to-1 write of bit 0. They read 0 until the first capture.
- R5: Bit 5 of 0x20 reads the hot-plug input level two clock edges after the input changes. Writes to bit 5 have no effect.
- R6: A change of the synchronized hot-plug level in either direction sets the interrupt latch only while `dig_out_sel` is 1.
- R7: Bit 7 of 0x20 is the read/write interrupt enable. `irq_pull_low` is 1 exactly when the latch, this enable and the driver enable are all 1.
- R8: The control register at address 0x1E holds the clear request in bit 0 and the pin-driver enable in bit 1, and both read back. A write that takes bit 0 from 1 to 0 clears the latch.
- R9: A hot-plug change while the clear request is 1 does not set the latch. A change after the clear request returns to 0 sets it again.
- R10: Reads from any address other than 0x20 or 0x1E return 0. Writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dac_cmp | input | 3 | Per-output comparator result, 1 = unterminated |
| dac_hold | output | 1 | Holds the analog outputs steady while sensing |
| hpd_in | input | 1 | Asynchronous hot-plug-detect level |
| dig_out_sel | input | 1 | Digital output currently selected |
| irq_pull_low | output | 1 | Open-drain request to pull the shared interrupt pin low |

## Verification
The assertions assume that `dac_cmp` is stable during the cycle in which sense is cleared. They also assume that `hpd_in` changes at most once every few cycles, so each edge passes through the synchronizer on its own. The stimulus changes the hot-plug input only at negative clock edges and then waits four cycles before the next action. It holds `dig_out_sel` constant across that whole window. All register writes are single-cycle strobes driven away from the active edge.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_OUTS   = 3;
  localparam logic [ADDR_W-1:0] SENSE_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h1E;
  // sense register bit positions
  localparam int unsigned B_SENSE  = 0;
  localparam int unsigned B_STAT_LO = 1;
  localparam int unsigned B_LEVEL  = 5;
  localparam int unsigned B_IEN    = 7;
  // control register bit positions
  localparam int unsigned B_CLR    = 0;
  localparam int unsigned B_DRV    = 1;
endpackage

// File: rtl/hpd_sync_edge.sv
module hpd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic change
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level  = chain_q[STAGES-1];
  assign change = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/sense_capture.sv
module sense_capture #(
  parameter int unsigned N_OUTS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sense,
  input  logic [N_OUTS-1:0] cmp,
  output logic              sense,
  output logic [N_OUTS-1:0] status
);
  logic              sense_q, sense_d;
  logic [N_OUTS-1:0] status_q, status_d;
  logic              done_q, done_d;
  logic              capture;

  always_comb begin
    capture  = wr_en && sense_q && !wr_sense;
    sense_d  = wr_en ? wr_sense : sense_q;
    status_d = capture ? cmp : status_q;
    done_d   = done_q || capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= 1'b0;
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      sense_q  <= sense_d;
      status_q <= status_d;
      done_q   <= done_d;
    end
  end

  assign sense  = sense_q;
  assign status = done_q ? status_q : '0;
endmodule

// File: rtl/hpd_irq_latch.sv
module hpd_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic change,
  input  logic dig_sel,
  input  logic ctl_wr,
  input  logic wr_clr,
  input  logic wr_drv,
  output logic clr_req,
  output logic drv_en,
  output logic pending
);
  logic clr_q, clr_d;
  logic drv_q, drv_d;
  logic pend_q, pend_d;
  logic release_pulse;

  always_comb begin
    release_pulse = ctl_wr && clr_q && !wr_clr;
    clr_d  = ctl_wr ? wr_clr : clr_q;
    drv_d  = ctl_wr ? wr_drv : drv_q;
    pend_d = pend_q;
    if (release_pulse) begin
      pend_d = 1'b0;
    end else if (change && dig_sel && !clr_q) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      drv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      clr_q  <= clr_d;
      drv_q  <= drv_d;
      pend_q <= pend_d;
    end
  end

  assign clr_req = clr_q;
  assign drv_en  = drv_q;
  assign pending = pend_q;
endmodule

// File: rtl/hpd_sense_ctrl.sv
module hpd_sense_ctrl
  import hpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_OUTS-1:0] dac_cmp,
  output logic              dac_hold,
  input  logic              hpd_in,
  input  logic              dig_out_sel,
  output logic              irq_pull_low
);
  logic              sel_sense, sel_ctrl;
  logic              wr_sense, wr_ctrl;
  logic              hpd_level, hpd_change;
  logic              sense_bit;
  logic [N_OUTS-1:0] status_bits;
  logic              ien_q, ien_d;
  logic              clr_req, drv_en, pending;

  always_comb begin
    sel_sense = (reg_addr == SENSE_ADDR);
    sel_ctrl  = (reg_addr == CTRL_ADDR);
    wr_sense  = reg_we && sel_sense;
    wr_ctrl   = reg_we && sel_ctrl;
    ien_d     = wr_sense ? reg_wdata[B_IEN] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= 1'b0;
    else        ien_q <= ien_d;
  end

  hpd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hpd_in),
    .level(hpd_level), .change(hpd_change)
  );

  sense_capture #(.N_OUTS(N_OUTS)) u_sense (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sense),
    .wr_sense(reg_wdata[B_SENSE]), .cmp(dac_cmp),
    .sense(sense_bit), .status(status_bits)
  );

  hpd_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .change(hpd_change), .dig_sel(dig_out_sel),
    .ctl_wr(wr_ctrl), .wr_clr(reg_wdata[B_CLR]), .wr_drv(reg_wdata[B_DRV]),
    .clr_req(clr_req), .drv_en(drv_en), .pending(pending)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_sense) begin
      reg_rdata[B_SENSE]                      = sense_bit;
      reg_rdata[B_STAT_LO +: N_OUTS]          = status_bits;
      reg_rdata[B_LEVEL]                      = hpd_level;
      reg_rdata[B_IEN]                        = ien_q;
    end else if (sel_ctrl) begin
      reg_rdata[B_CLR] = clr_req;
      reg_rdata[B_DRV] = drv_en;
    end
  end

  assign dac_hold     = sense_bit;
  assign irq_pull_low = pending && ien_q && drv_en;
endmodule

// File: rtl/hpd_sense_chk.sv
module hpd_sense_chk
  import hpd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [N_OUTS-1:0] dac_cmp,
  input logic              dac_hold,
  input logic [N_OUTS-1:0] status_bits,
  input logic              ien_q,
  input logic              drv_en,
  input logic              clr_req,
  input logic              pending,
  input logic              irq_pull_low
);
  logic wr_s, wr_c;
  assign wr_s = reg_we && (reg_addr == SENSE_ADDR);
  assign wr_c = reg_we && (reg_addr == CTRL_ADDR);

  a_r2_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s |=> (dac_hold == $past(reg_wdata[B_SENSE])));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && dac_hold && !reg_wdata[B_SENSE]) |=> (status_bits == $past(dac_cmp)));

  a_r4_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_s && dac_hold && !reg_wdata[B_SENSE]) |=> $stable(status_bits));

  a_r7_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low |-> (ien_q && drv_en && pending));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && clr_req && !reg_wdata[B_CLR]) |=> !pending);

  a_r9_no_set_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !$rose(pending));
endmodule

bind hpd_sense_ctrl hpd_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dac_cmp(dac_cmp), .dac_hold(dac_hold),
  .status_bits(status_bits), .ien_q(ien_q), .drv_en(drv_en),
  .clr_req(clr_req), .pending(pending), .irq_pull_low(irq_pull_low)
);

// File: tb/sim_hpd_sense_ctrl.sv
`timescale 1ns/1ps
module sim_hpd_sense_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] dac_cmp = 3'b000;
  logic       dac_hold;
  logic       hpd_in = 1'b0;
  logic       dig_out_sel = 1'b0;
  logic       irq_pull_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  bit       m_sense, m_ien, m_clr, m_drv, m_pend, m_hpd;
  bit [2:0] m_stat;

  always #5 clk = ~clk;

  hpd_sense_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dac_cmp(dac_cmp),
    .dac_hold(dac_hold), .hpd_in(hpd_in), .dig_out_sel(dig_out_sel),
    .irq_pull_low(irq_pull_low)
  );

  function automatic logic [7:0] exp_sense();
    return {m_ien, 1'b0, m_hpd, 1'b0, m_stat, m_sense};
  endfunction
  function automatic logic [7:0] exp_ctrl();
    return {6'b0, m_drv, m_clr};
  endfunction
  function automatic bit exp_pin();
    return m_pend && m_ien && m_drv;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'h20) begin
      if (m_sense && !d[0]) m_stat = dac_cmp;
      m_sense = d[0];
      m_ien = d[7];
    end else if (a == 8'h1E) begin
      if (m_clr && !d[0]) m_pend = 1'b0;
      m_clr = d[0];
      m_drv = d[1];
    end
  endtask

  task automatic hpd_toggle(input bit sel);
    @(negedge clk);
    dig_out_sel = sel;
    hpd_in = ~hpd_in;
    repeat (4) @(negedge clk);
    m_hpd = hpd_in;
    if (sel && !m_clr) m_pend = 1'b1;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(8'h20, d); check({tag, " sense reg"}, d, exp_sense());
    rd(8'h1E, d); check({tag, " ctrl reg"}, d, exp_ctrl());
    check({tag, " pin"}, {7'b0, irq_pull_low}, {7'b0, exp_pin()});
    check({tag, " hold"}, {7'b0, dac_hold}, {7'b0, m_sense});
  endtask

  initial begin
    logic [7:0] d;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(8'h20, d); check("R1 sense reg reset", d, 8'h00);
    rd(8'h1E, d); check("R1 ctrl reg reset", d, 8'h00);
    check("R1 pin reset", {7'b0, irq_pull_low}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2/R3: sense sequence
    dac_cmp = 3'b101;
    wr(8'h20, 8'h01);
    check("R2 hold set", {7'b0, dac_hold}, 8'h01);
    rd(8'h20, d); check("R4 status zero before capture", d & 8'h0E, 8'h00);
    wr(8'h20, 8'h00);
    rd(8'h20, d); check("R3 capture 101", d, 8'h0A);
    // R4: 0->0 write does not recapture
    dac_cmp = 3'b010;
    wr(8'h20, 8'h00);
    rd(8'h20, d); check("R4 no recapture", d, 8'h0A);
    wr(8'h20, 8'h01); wr(8'h20, 8'h01);
    wr(8'h20, 8'h00);
    rd(8'h20, d); check("R3 capture 010", d, 8'h04);

    // R5: level latency, writes to bit5 ignored
    @(negedge clk); hpd_in = 1'b1; dig_out_sel = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    reg_addr = 8'h20; #1;
    check("R5 level after two edges", {7'b0, reg_rdata[5]}, 8'h01);
    repeat (3) @(negedge clk);
    m_hpd = 1'b1;
    wr(8'h20, 8'h00);
    check_all("R5 write bit5 zero ignored, R6 no latch unselected");

    // R6/R7: latch with gating
    hpd_toggle(1'b1);
    check_all("R6 latch set, R7 pin off");
    wr(8'h20, 8'h80);
    check_all("R7 ien only");
    wr(8'h1E, 8'h02);
    check_all("R7 pin pulled low");
    // R8/R9
    wr(8'h1E, 8'h03);
    check_all("R8 clear request high keeps latch");
    hpd_toggle(1'b1);
    check_all("R9 change during clear ignored");
    wr(8'h1E, 8'h02);
    check_all("R8 latch cleared");
    hpd_toggle(1'b1);
    check_all("R9 set again after clear");
    // R10
    wr(8'h21, 8'hFF);
    rd(8'h21, d); check("R10 unmapped read", d, 8'h00);
    check_all("R10 unmapped write no effect");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom_range(0, 4);
      case (op)
        0: wr(8'h20, 8'($urandom()));
        1: wr(8'h1E, 8'($urandom()));
        2: hpd_toggle(1'($urandom()));
        3: dac_cmp = 3'($urandom());
        default: wr(8'($urandom_range(0, 31)), 8'($urandom()));
      endcase
      check_all("R3 R6 R7 R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule